// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block settles the outcome of a double-precision fused multiply-add, z + x·y, or its negated-product form z − x·y, whenever an operand makes the result special. Each operand arrives both in raw form (64 bits) and already classified, together with its sign. The block also receives a negate-product flag and the current rounding mode.

When a special case applies, the block raises `special_o` and drives the final 64-bit result. It also raises `invalid_o` when the operation is invalid. Otherwise it raises `to_datapath_o`, so that the mantissa datapath computes the result. The block does no mantissa arithmetic.

Class codes on the `*_cls_i` inputs are: 0 zero, 1 normal, 2 denormal, 3 infinity, 4 quiet NaN, 5 signalling NaN. Codes 6 and 7 are treated as finite nonzero. Rounding mode code 3 means round toward minus infinity. The default NaN is the parameter `DNAN`, with default value 64'h7FF8_0000_0000_0000. An infinity of sign s is written {s, 11'h7FF, 52'h0}.

Top module: `fma_special_resolve`

## Requirements
- R1: NaN operands are examined in a fixed priority: signalling NaN in z, then in x, then in y; then quiet NaN in z, then in x, then in y. The first operand that matches decides the result.
- R2: When the deciding operand is a signalling NaN, the result is that raw operand with bit 51 set. `invalid_o` is 1.
- R3: When the deciding operand is a quiet NaN, the result is that raw operand unchanged. `invalid_o` is 0.
- R4: When no operand is a NaN and one of x, y is infinity while the other is zero, the result is `DNAN` and `invalid_o` is 1.
- R5: The product sign is x_sgn XOR y_sgn XOR neg_prod. Suppose no operand is a NaN and the product is infinite (at least one of x, y is infinity, and neither is zero). If z is not an infinity of the opposite sign, the result is an infinity with the product sign and `invalid_o` is 0.
- R6: When the product is infinite and z is an infinity whose sign differs from the product sign, the result is `DNAN` and `invalid_o` is 1.
- R7: When no operand is a NaN, the product is zero (at least one of x, y is zero, and neither is infinity) and z is infinity, the result is an infinity with z's sign.
- R8: When the product is zero and z is zero, the result depends on the signs. If z_sgn equals the product sign, the result is z unchanged. Otherwise the result is +0, or −0 when the rounding mode is 3.
- R9: When the product is zero and z is finite and nonzero, the result is z unchanged.
- R10: When x and y are both finite and nonzero and z is infinity, the result is an infinity with z's sign.
- R11: In every other case, `special_o` is 0, `to_datapath_o` is 1, `invalid_o` is 0 and the result is 0. `to_datapath_o` is always the inverse of `special_o`, and `invalid_o` is never 1 without `special_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_cls_i | input | 3 | Class code of x |
| y_cls_i | input | 3 | Class code of y |
| z_cls_i | input | 3 | Class code of z |
| x_sgn_i | input | 1 | Sign of x |
| y_sgn_i | input | 1 | Sign of y |
| z_sgn_i | input | 1 | Sign of z |
| x_i | input | 64 | Raw x operand |
| y_i | input | 64 | Raw y operand |
| z_i | input | 64 | Raw z operand (addend) |
| neg_prod_i | input | 1 | 1 selects z − x·y |
| rnd_mode_i | input | 2 | Rounding mode; 3 is round toward −∞ |
| special_o | output | 1 | Result is decided here |
| result_o | output | 64 | Special result, zero otherwise |
| invalid_o | output | 1 | Invalid-operation flag |
| to_datapath_o | output | 1 | Result must come from the datapath |

## Verification
The block is purely combinational, so a wrong decision appears on the outputs in the same cycle as the operands that cause it. Two kinds of fault are likely. A misordered priority shows as the wrong NaN payload, or as a cleared invalid flag. A wrong sign term shows as a flipped top bit on an infinity or a zero. The sweep uses a distinct payload for each operand, so the payload on `result_o` identifies which operand won.

// File: rtl/fma_special_resolve.sv
module fma_special_resolve #(
  parameter logic [63:0] DNAN = 64'h7FF8_0000_0000_0000
) (
  input  logic [2:0]  x_cls_i,
  input  logic [2:0]  y_cls_i,
  input  logic [2:0]  z_cls_i,
  input  logic        x_sgn_i,
  input  logic        y_sgn_i,
  input  logic        z_sgn_i,
  input  logic [63:0] x_i,
  input  logic [63:0] y_i,
  input  logic [63:0] z_i,
  input  logic        neg_prod_i,
  input  logic [1:0]  rnd_mode_i,
  output logic        special_o,
  output logic [63:0] result_o,
  output logic        invalid_o,
  output logic        to_datapath_o
);
  localparam logic [2:0] C_ZERO = 3'd0;
  localparam logic [2:0] C_INF  = 3'd3;
  localparam logic [2:0] C_QNAN = 3'd4;
  localparam logic [2:0] C_SNAN = 3'd5;
  localparam logic [1:0] RM_DOWN = 2'd3;
  localparam int QUIET_BIT = 51;
  localparam logic [63:0] QMASK = 64'h1 << QUIET_BIT;

  logic x_sn, y_sn, z_sn, x_qn, y_qn, z_qn;
  logic x_inf, y_inf, z_inf, x_zero, y_zero, z_zero;
  logic psgn, prod_inf, prod_zero;

  assign x_sn   = x_cls_i == C_SNAN;
  assign y_sn   = y_cls_i == C_SNAN;
  assign z_sn   = z_cls_i == C_SNAN;
  assign x_qn   = x_cls_i == C_QNAN;
  assign y_qn   = y_cls_i == C_QNAN;
  assign z_qn   = z_cls_i == C_QNAN;
  assign x_inf  = x_cls_i == C_INF;
  assign y_inf  = y_cls_i == C_INF;
  assign z_inf  = z_cls_i == C_INF;
  assign x_zero = x_cls_i == C_ZERO;
  assign y_zero = y_cls_i == C_ZERO;
  assign z_zero = z_cls_i == C_ZERO;

  assign psgn      = x_sgn_i ^ y_sgn_i ^ neg_prod_i;
  assign prod_inf  = (x_inf | y_inf) & ~(x_zero | y_zero);
  assign prod_zero = (x_zero | y_zero) & ~(x_inf | y_inf);

  function automatic logic [63:0] inf_of(input logic s);
    return {s, 11'h7FF, 52'h0};
  endfunction

  always_comb begin
    special_o = 1'b1;
    invalid_o = 1'b0;
    result_o  = 64'h0;
    if (z_sn) begin
      invalid_o = 1'b1;
      result_o  = z_i | QMASK;
    end else if (x_sn) begin
      invalid_o = 1'b1;
      result_o  = x_i | QMASK;
    end else if (y_sn) begin
      invalid_o = 1'b1;
      result_o  = y_i | QMASK;
    end else if (z_qn) begin
      result_o = z_i;
    end else if (x_qn) begin
      result_o = x_i;
    end else if (y_qn) begin
      result_o = y_i;
    end else if ((x_inf & y_zero) | (x_zero & y_inf)) begin
      invalid_o = 1'b1;
      result_o  = DNAN;
    end else if (prod_inf) begin
      if (z_inf && (z_sgn_i != psgn)) begin
        invalid_o = 1'b1;
        result_o  = DNAN;
      end else begin
        result_o = inf_of(psgn);
      end
    end else if (prod_zero) begin
      if (z_inf)
        result_o = inf_of(z_sgn_i);
      else if (z_zero && (z_sgn_i != psgn))
        result_o = {rnd_mode_i == RM_DOWN, 63'h0};
      else
        result_o = z_i;
    end else if (z_inf) begin
      result_o = inf_of(z_sgn_i);
    end else begin
      special_o = 1'b0;
    end
  end

  assign to_datapath_o = ~special_o;
endmodule

// File: rtl/fma_special_resolve_chk.sv
module fma_special_resolve_chk #(
  parameter logic [63:0] DNAN = 64'h7FF8_0000_0000_0000
) (
  input logic [2:0]  x_cls_i,
  input logic [2:0]  y_cls_i,
  input logic [2:0]  z_cls_i,
  input logic        special_o,
  input logic [63:0] result_o,
  input logic        invalid_o,
  input logic        to_datapath_o
);
  logic any_sn, any_qn, known;
  assign any_sn = (x_cls_i == 3'd5) | (y_cls_i == 3'd5) | (z_cls_i == 3'd5);
  assign any_qn = (x_cls_i == 3'd4) | (y_cls_i == 3'd4) | (z_cls_i == 3'd4);
  assign known  = !$isunknown({x_cls_i, y_cls_i, z_cls_i, special_o, invalid_o, to_datapath_o});

  always_comb begin
    if (known) begin
      // R11
      path_excl_chk: assert (to_datapath_o != special_o);
      // R11
      inv_needs_special_chk: assert (!invalid_o || special_o);
      // R2
      snan_flags_chk: assert (!any_sn || (invalid_o && special_o));
      // R3
      qnan_quiet_chk: assert (any_sn || !any_qn || (!invalid_o && special_o));
      // R4
      inf_zero_chk: assert (any_sn || any_qn ||
        !(((x_cls_i == 3'd3) && (y_cls_i == 3'd0)) || ((x_cls_i == 3'd0) && (y_cls_i == 3'd3))) ||
        (invalid_o && result_o == DNAN));
    end
  end
endmodule

bind fma_special_resolve fma_special_resolve_chk #(.DNAN(DNAN)) chk (
  .x_cls_i(x_cls_i), .y_cls_i(y_cls_i), .z_cls_i(z_cls_i),
  .special_o(special_o), .result_o(result_o), .invalid_o(invalid_o),
  .to_datapath_o(to_datapath_o)
);

// File: tb/fma_special_resolve_test.sv
`timescale 1ns/1ps
module fma_special_resolve_test;
  localparam logic [63:0] DNAN = 64'h7FF8_0000_0000_0000;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [2:0]  xc, yc, zc;
  logic        xs, ys, zs, neg;
  logic [1:0]  rm;
  logic [63:0] xv, yv, zv;
  logic        spec, inv, go;
  logic [63:0] res;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  fma_special_resolve #(.DNAN(DNAN)) uut (
    .x_cls_i(xc), .y_cls_i(yc), .z_cls_i(zc),
    .x_sgn_i(xs), .y_sgn_i(ys), .z_sgn_i(zs),
    .x_i(xv), .y_i(yv), .z_i(zv),
    .neg_prod_i(neg), .rnd_mode_i(rm),
    .special_o(spec), .result_o(res), .invalid_o(inv), .to_datapath_o(go)
  );

  function automatic logic [63:0] mk(input int c, input logic s, input logic [7:0] tag);
    case (c)
      0: return {s, 63'h0};
      1: return {s, 11'h400, 44'h0, tag};
      2: return {s, 11'h000, 44'h0, tag};
      3: return {s, 11'h7FF, 52'h0};
      4: return {s, 11'h7FF, 1'b1, 43'h0, tag};
      default: return {s, 11'h7FF, 1'b0, 43'h0, tag};
    endcase
  endfunction

  task automatic check(input string req, input logic es, input logic [63:0] er, input logic ei);
    checks++;
    if (spec !== es || go !== !es || res !== er || inv !== ei) begin
      fails++;
      $display("FAIL %s: got spec=%0b go=%0b res=%h inv=%0b, expected spec=%0b go=%0b res=%h inv=%0b",
               req, spec, go, res, inv, es, !es, er, ei);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    xc = 0; yc = 0; zc = 0; xs = 0; ys = 0; zs = 0; neg = 0; rm = 0;
    xv = 0; yv = 0; zv = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    @(negedge clk);
    check("R8 reset-state", 1'b1, 64'h0, 1'b0);

    for (int cz = 0; cz < 6; cz++)
    for (int cx = 0; cx < 6; cx++)
    for (int cy = 0; cy < 6; cy++)
    for (int sg = 0; sg < 8; sg++)
    for (int n = 0; n < 2; n++)
    for (int r = 0; r < 4; r++) begin
      logic sx, sy, sz, ps, es, ei;
      logic [63:0] ax, ay, az, er;
      string req;
      sx = sg[0]; sy = sg[1]; sz = sg[2];
      ax = mk(cx, sx, 8'h11); ay = mk(cy, sy, 8'h22); az = mk(cz, sz, 8'h33);
      @(posedge clk);
      xc = 3'(cx); yc = 3'(cy); zc = 3'(cz);
      xs = sx; ys = sy; zs = sz; neg = n[0]; rm = 2'(r);
      xv = ax; yv = ay; zv = az;
      ps = sx ^ sy ^ n[0];
      es = 1; ei = 0; er = 0;
      if (cz == 5 || cx == 5 || cy == 5) begin
        req = "R1/R2 snan"; ei = 1;
        er = (cz == 5 ? az : cx == 5 ? ax : ay);
        er[51] = 1'b1;
      end else if (cz == 4 || cx == 4 || cy == 4) begin
        req = "R1/R3 qnan";
        er = (cz == 4 ? az : cx == 4 ? ax : ay);
      end else if ((cx == 3 && cy == 0) || (cx == 0 && cy == 3)) begin
        req = "R4 inf*0"; ei = 1; er = DNAN;
      end else if (cx == 3 || cy == 3) begin
        if (cz == 3 && sz != ps) begin req = "R6 inf-inf"; ei = 1; er = DNAN; end
        else begin req = "R5 inf product"; er = {ps, 11'h7FF, 52'h0}; end
      end else if (cx == 0 || cy == 0) begin
        if (cz == 3) begin req = "R7 zero prod inf z"; er = {sz, 11'h7FF, 52'h0}; end
        else if (cz == 0) begin
          req = "R8 zero+zero";
          er = (sz == ps) ? az : {(r == 3), 63'h0};
        end else begin req = "R9 zero prod finite z"; er = az; end
      end else if (cz == 3) begin
        req = "R10 finite prod inf z"; er = {sz, 11'h7FF, 52'h0};
      end else begin
        req = "R11 datapath"; es = 0;
      end
      @(negedge clk);
      check(req, es, er, ei);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule